// File: doc/BRIEF.md
# Asymmetric Three-Way Decode Allocator

This block sits behind an instruction-length stage and in front of register renaming. Each cycle it is offered up to three pre-decoded instructions on three input lanes. Each lane carries a tag and a micro-op count. The lanes are always filled from lane 0 upward. The block assigns the offered instructions in program order to three decode slots. Slot 0 accepts an instruction of one to four micro-ops. Slots 1 and 2 accept only single micro-op instructions. An instruction with more than four micro-ops is handed to a sequencer path. That path plays out its micro-ops from a synthesizable stub ROM over as many cycles as it needs.

The micro-ops produced in a cycle are written into a six-entry decoded queue, which is also the output register. Adjacent queue entries form fused pairs. The consumer drains the whole queue with a valid/ready handshake. The queue is refilled only when it is empty or being drained in the same cycle. When a sequenced instruction yields more micro-ops than the queue holds, the remainder is written on the following free cycles. The input side reports how many lanes were consumed through `inTake`, and the feeding stage shifts its window by that amount. A synchronous flush discards the queue contents and any unfinished sequence.

Top module: `triad_decode_alloc`

## Requirements
- R1: After reset the queue is empty (`outValid` low) and `inReady` is high.
- R2: An instruction on lane 0 with a count of 1 to 4 is always consumed when `inReady` is high. Its micro-ops fill the first queue entries. Micro-op k of an instruction is encoded as {tag, k} with the index in the low `CNT_W` bits.
- R3: Lane 1 is consumed only if it is valid, its count is 1, and lane 0 went to slot 0. Lane 2 is consumed only if lane 1 was consumed and lane 2 has a count of 1. A multi-micro-op lane blocks itself and every younger lane that cycle.
- R4: An instruction on lane 0 with a count above 4 is sent to the sequencer, and it is the only instruction consumed in that cycle.
- R5: The sequencer writes min(6, remaining) micro-ops per free cycle, starting with the cycle of acceptance. `inReady` stays low until its last group is written. For example, counts 6, 7 and 15 hold `inReady` low for 0, 1 and 2 cycles respectively when the output is always ready.
- R6: `outCount` gives the number of valid entries, from 1 to 6, whenever `outValid` is high. Entry j lies at bits [j*UW +: UW], and entries 2i and 2i+1 form fused pair i. Each written group appears as exactly one output batch.
- R7: While `outValid` is high and `outReady` is low, the output holds steady, `inReady` is low and `inTake` is 0.
- R8: A flush clears the queue and any pending sequence in one cycle. On the following cycle `outValid` is low and `inReady` is high, and no leftover micro-op from the flushed sequence appears afterwards.
- R9: Micro-ops leave the block in program order across all batches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Synchronous flush of queue and sequencer |
| inValid | input | 3 | Lane valid bits, filled from lane 0 upward |
| inCount | input | 3*CNT_W | Micro-op count per lane, lane i at [i*CNT_W +: CNT_W] |
| inTag | input | 3*TAG_W | Instruction tag per lane, lane i at [i*TAG_W +: TAG_W] |
| inReady | output | 1 | Block can consume instructions this cycle |
| inTake | output | 2 | Number of lanes consumed this cycle |
| outValid | output | 1 | Queue holds micro-ops |
| outReady | input | 1 | Consumer drains the whole queue |
| outCount | output | $clog2(Q_DEPTH+1) | Number of valid queue entries |
| outUops | output | Q_DEPTH*(TAG_W+CNT_W) | Queue entries, fused in pairs |

## Verification
The bench builds the block with its default parameters: four-bit counts, six-bit tags, a four-micro-op slot 0 and a six-entry queue. With four-bit counts an instruction can reach fifteen micro-ops, so a sequence can span up to three queue writes. With a six-entry queue, a 4+1+1 group fills the queue exactly, and a six-micro-op sequence finishes in its acceptance cycle. The stimulus mixes simple runs, blocked multi-micro-op lanes, sequenced instructions of several lengths and a repeating output stall. Together these reach every slot rule and both exits from the sequencer.

// File: rtl/triad_dec_pkg.sv
package triad_dec_pkg;
  // Strobes from the allocation control to the queue datapath.
  typedef struct packed {
    logic       load;     // write a new group into the queue
    logic       clear;    // flush everything
    logic       seqMode;  // group comes from the sequencer path
    logic [2:0] laneUse;  // lanes decoded through slots 0..2
  } allocStrobe_t;
endpackage

// File: rtl/triad_dec_ctrl.sv
module triad_dec_ctrl
  import triad_dec_pkg::*;
#(
  parameter int TAG_W    = 6,
  parameter int CNT_W    = 4,
  parameter int WIDE_MAX = 4,
  parameter int Q_DEPTH  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [2:0]         inValid,
  input  logic [3*CNT_W-1:0] inCount,
  input  logic [3*TAG_W-1:0] inTag,
  input  logic               outValid,
  input  logic               outReady,
  output logic               inReady,
  output logic [1:0]         inTake,
  output allocStrobe_t       strobe,
  output logic [TAG_W-1:0]   seqTag,
  output logic [CNT_W-1:0]   seqBase,
  output logic [CNT_W:0]     seqNum
);
  localparam logic [CNT_W:0] QD_EXT   = (CNT_W+1)'(Q_DEPTH);
  localparam logic [CNT_W:0] WIDE_EXT = (CNT_W+1)'(WIDE_MAX);

  logic [CNT_W-1:0] cntL [3];
  logic [TAG_W-1:0] tagL [3];
  for (genvar g = 0; g < 3; g++) begin : g_lane
    assign cntL[g] = inCount[g*CNT_W +: CNT_W];
    assign tagL[g] = inTag[g*TAG_W +: TAG_W];
  end

  logic             seqActive;
  logic [TAG_W-1:0] seqTagQ;
  logic [CNT_W-1:0] seqNextQ, seqTotalQ;
  logic [CNT_W:0]   seqRem;
  logic             qFree, startSeq;

  function automatic logic [CNT_W:0] clampQ(input logic [CNT_W:0] r);
    return (r > QD_EXT) ? QD_EXT : r;
  endfunction

  assign qFree   = !outValid || outReady;
  assign seqRem  = {1'b0, seqTotalQ} - {1'b0, seqNextQ};
  assign inReady = !flush && qFree && !seqActive;

  always_comb begin
    strobe       = '0;
    strobe.clear = flush;
    inTake       = 2'd0;
    seqTag       = seqTagQ;
    seqBase      = seqNextQ;
    seqNum       = '0;
    startSeq     = 1'b0;
    if (!flush && qFree) begin
      if (seqActive) begin
        strobe.load    = 1'b1;
        strobe.seqMode = 1'b1;
        seqNum         = clampQ(seqRem);
      end else if (inValid[0]) begin
        strobe.load = 1'b1;
        inTake      = 2'd1;
        if ({1'b0, cntL[0]} > WIDE_EXT) begin
          strobe.seqMode = 1'b1;
          seqTag         = tagL[0];
          seqBase        = '0;
          seqNum         = clampQ({1'b0, cntL[0]});
          startSeq       = 1'b1;
        end else begin
          strobe.laneUse[0] = 1'b1;
          if (inValid[1] && cntL[1] == CNT_W'(1)) begin
            strobe.laneUse[1] = 1'b1;
            inTake            = 2'd2;
            if (inValid[2] && cntL[2] == CNT_W'(1)) begin
              strobe.laneUse[2] = 1'b1;
              inTake            = 2'd3;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      seqActive <= 1'b0;
      seqTagQ   <= '0;
      seqNextQ  <= '0;
      seqTotalQ <= '0;
    end else if (startSeq) begin
      seqTagQ   <= tagL[0];
      seqTotalQ <= cntL[0];
      seqNextQ  <= CNT_W'(Q_DEPTH);
      seqActive <= {1'b0, cntL[0]} > QD_EXT;
    end else if (seqActive && strobe.load) begin
      seqNextQ <= seqNextQ + CNT_W'(seqNum);
      if (seqRem <= QD_EXT) seqActive <= 1'b0;
    end
  end

  // R5: a long instruction leaves the input side closed on the next cycle
  p_busy_after_long_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inTake != 2'd0 && {1'b0, cntL[0]} > QD_EXT) |=> !inReady);
  // R3: a second lane is only taken when it is a single micro-op
  p_lane1_simple_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inTake >= 2'd2) |-> (cntL[1] == CNT_W'(1) && cntL[0] <= CNT_W'(WIDE_MAX)));
  // R4: a sequenced instruction travels alone
  p_seq_alone_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inTake != 2'd0 && {1'b0, cntL[0]} > WIDE_EXT) |-> inTake == 2'd1);
  // R7: a stalled queue accepts nothing
  p_stall_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |-> (inTake == 2'd0));
endmodule

// File: rtl/triad_dec_dp.sv
module triad_dec_dp
  import triad_dec_pkg::*;
#(
  parameter int TAG_W    = 6,
  parameter int CNT_W    = 4,
  parameter int WIDE_MAX = 4,
  parameter int Q_DEPTH  = 6,
  localparam int UW      = TAG_W + CNT_W,
  localparam int QW      = $clog2(Q_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  allocStrobe_t          strobe,
  input  logic [3*CNT_W-1:0]    inCount,
  input  logic [3*TAG_W-1:0]    inTag,
  input  logic [TAG_W-1:0]      seqTag,
  input  logic [CNT_W-1:0]      seqBase,
  input  logic [CNT_W:0]        seqNum,
  input  logic                  outReady,
  output logic                  outValid,
  output logic [QW-1:0]         outCount,
  output logic [Q_DEPTH*UW-1:0] outUops
);
  logic [CNT_W-1:0] cntL [3];
  logic [TAG_W-1:0] tagL [3];
  for (genvar g = 0; g < 3; g++) begin : g_lane
    assign cntL[g] = inCount[g*CNT_W +: CNT_W];
    assign tagL[g] = inTag[g*TAG_W +: TAG_W];
  end

  // Stub sequencer ROM: word for step k of a sequence.
  function automatic logic [UW-1:0] romWord(input logic [TAG_W-1:0] t,
                                            input logic [CNT_W-1:0] k);
    return {t, k};
  endfunction

  logic [Q_DEPTH*UW-1:0] packed_d;
  logic [QW-1:0]         nOut;

  always_comb begin
    int pos;
    packed_d = '0;
    pos      = 0;
    if (strobe.seqMode) begin
      for (int j = 0; j < Q_DEPTH; j++) begin
        if ((CNT_W+1)'(j) < seqNum)
          packed_d[j*UW +: UW] = romWord(seqTag, seqBase + CNT_W'(j));
      end
      nOut = QW'(seqNum);
    end else begin
      if (strobe.laneUse[0]) begin
        for (int k = 0; k < WIDE_MAX; k++) begin
          if (CNT_W'(k) < cntL[0]) begin
            packed_d[pos*UW +: UW] = {tagL[0], CNT_W'(k)};
            pos++;
          end
        end
      end
      for (int l = 1; l < 3; l++) begin
        if (strobe.laneUse[l]) begin
          packed_d[pos*UW +: UW] = {tagL[l], CNT_W'(0)};
          pos++;
        end
      end
      nOut = QW'(pos);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.clear) begin
      outCount <= '0;
      outUops  <= '0;
    end else if (strobe.load) begin
      outCount <= nOut;
      outUops  <= packed_d;
    end else if (outReady) begin
      outCount <= '0;
    end
  end

  assign outValid = outCount != '0;

  // R7: a stalled queue keeps its contents
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady && !strobe.clear) |=> ($stable(outUops) && $stable(outCount)));
  // R8: flush empties the queue on the next cycle
  p_flush_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clear |=> !outValid);
  // R6: occupancy stays within the queue
  p_count_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (outCount <= QW'(Q_DEPTH)));
endmodule

// File: rtl/triad_decode_alloc.sv
module triad_decode_alloc
  import triad_dec_pkg::*;
#(
  parameter int TAG_W    = 6,
  parameter int CNT_W    = 4,
  parameter int WIDE_MAX = 4,
  parameter int Q_DEPTH  = 6
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   flush,
  input  logic [2:0]                             inValid,
  input  logic [3*CNT_W-1:0]                     inCount,
  input  logic [3*TAG_W-1:0]                     inTag,
  output logic                                   inReady,
  output logic [1:0]                             inTake,
  output logic                                   outValid,
  input  logic                                   outReady,
  output logic [$clog2(Q_DEPTH+1)-1:0]           outCount,
  output logic [Q_DEPTH*(TAG_W+CNT_W)-1:0]       outUops
);
  allocStrobe_t     strobe;
  logic [TAG_W-1:0] seqTag;
  logic [CNT_W-1:0] seqBase;
  logic [CNT_W:0]   seqNum;

  triad_dec_ctrl #(.TAG_W(TAG_W), .CNT_W(CNT_W), .WIDE_MAX(WIDE_MAX), .Q_DEPTH(Q_DEPTH)) uCtrl (
    .clk(clk), .rst_n(rst_n), .flush(flush), .inValid(inValid), .inCount(inCount),
    .inTag(inTag), .outValid(outValid), .outReady(outReady), .inReady(inReady),
    .inTake(inTake), .strobe(strobe), .seqTag(seqTag), .seqBase(seqBase), .seqNum(seqNum));

  triad_dec_dp #(.TAG_W(TAG_W), .CNT_W(CNT_W), .WIDE_MAX(WIDE_MAX), .Q_DEPTH(Q_DEPTH)) uDp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .inCount(inCount), .inTag(inTag),
    .seqTag(seqTag), .seqBase(seqBase), .seqNum(seqNum), .outReady(outReady),
    .outValid(outValid), .outCount(outCount), .outUops(outUops));
endmodule

// File: tb/sim_triad_decode_alloc.sv
module sim_triad_decode_alloc;
  localparam int TAG_W = 6, CNT_W = 4, WIDE_MAX = 4, Q_DEPTH = 6;
  localparam int UW = TAG_W + CNT_W;
  localparam int QW = $clog2(Q_DEPTH + 1);
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0, flush = 0, outReady = 0;
  logic [2:0] inValid = '0;
  logic [3*CNT_W-1:0] inCount = '0;
  logic [3*TAG_W-1:0] inTag = '0;
  logic inReady, outValid;
  logic [1:0] inTake;
  logic [QW-1:0] outCount;
  logic [Q_DEPTH*UW-1:0] outUops;

  triad_decode_alloc #(.TAG_W(TAG_W), .CNT_W(CNT_W), .WIDE_MAX(WIDE_MAX), .Q_DEPTH(Q_DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .inValid(inValid), .inCount(inCount),
    .inTag(inTag), .inReady(inReady), .inTake(inTake), .outValid(outValid),
    .outReady(outReady), .outCount(outCount), .outUops(outUops));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, lowCnt = 0, cyc = 0;
  int sCnt[64], sTag[64];
  logic [UW-1:0] expU[$];
  int expB[$];

  int pat[28] = '{1,1,1, 2,1,1, 1,3,1, 4,1,2, 5, 1,1, 7, 1, 12, 1,1,1,1, 6, 3,3, 1, 15, 2};

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc++;

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    report();
    $finish;
  end

  function automatic int expTake(input int i, input int n);
    int t;
    if (sCnt[i] > WIDE_MAX) return 1;
    t = 1;
    if (i + 1 < n && sCnt[i+1] == 1) begin
      t = 2;
      if (i + 2 < n && sCnt[i+2] == 1) t = 3;
    end
    return t;
  endfunction

  // Driver side of the scoreboard: expected micro-ops and batch sizes.
  task automatic pushExpected(input int i, input int e);
    int total = 0;
    for (int m = 0; m < e; m++) begin
      int c = sCnt[i+m];
      for (int k = 0; k < c; k++) expU.push_back({TAG_W'(sTag[i+m]), CNT_W'(k)});
      if (c > WIDE_MAX) begin
        int rem = c;
        while (rem > 0) begin
          expB.push_back(rem > Q_DEPTH ? Q_DEPTH : rem);
          rem -= Q_DEPTH;
        end
      end else total += c;
    end
    if (total > 0) expB.push_back(total);
  endtask

  // Monitor side: pop and compare a drained batch.
  task automatic monitorStep();
    if (outValid && outReady) begin
      if (expB.size() == 0) chk(0, "R6 unexpected batch", int'(outCount), 0);
      else begin
        int b = expB.pop_front();
        chk(int'(outCount) == b, "R6 batch size", int'(outCount), b);
        for (int j = 0; j < int'(outCount); j++) begin
          logic [UW-1:0] got = outUops[j*UW +: UW];
          if (expU.size() == 0) chk(0, "R9 extra uop", int'(got), 0);
          else begin
            logic [UW-1:0] want = expU.pop_front();
            chk(got == want, "R9/R2 uop order", int'(got), int'(want));
          end
        end
      end
    end
  endtask

  task automatic runStream(input int n, input bit backPressure);
    int idx = 0, guard = 0;
    lowCnt = 0;
    while ((idx < n || expB.size() > 0) && guard < 3000) begin
      @(negedge clk);
      for (int l = 0; l < 3; l++) begin
        inValid[l] = (idx + l < n);
        inCount[l*CNT_W +: CNT_W] = (idx + l < n) ? CNT_W'(sCnt[idx+l]) : '0;
        inTag[l*TAG_W +: TAG_W]   = (idx + l < n) ? TAG_W'(sTag[idx+l]) : '0;
      end
      outReady = backPressure ? (guard % 3 != 1) : 1'b1;
      #1;
      monitorStep();
      if (outValid && !outReady) begin
        chk(inReady == 0, "R7 ready during stall", int'(inReady), 0);
        chk(inTake == 0, "R7 take during stall", int'(inTake), 0);
      end
      if (inReady && inValid[0]) begin
        int e = expTake(idx, n);
        chk(int'(inTake) == e, sCnt[idx] > WIDE_MAX ? "R4 seq take" : "R3 slot take",
            int'(inTake), e);
        pushExpected(idx, e);
        idx += e;
      end else if (!inReady) begin
        lowCnt++;
        chk(inTake == 0, "R5 take while busy", int'(inTake), 0);
      end
      guard++;
    end
    @(negedge clk);
    inValid = '0;
    outReady = 0;
  endtask

  task automatic seqBusy(input int c, input int expLow);
    sCnt[0] = c; sTag[0] = 40 + c;
    runStream(1, 0);
    chk(lowCnt == expLow, "R5 busy cycles", lowCnt, expLow);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk(outValid == 0, "R1 reset outValid", int'(outValid), 0);
    chk(inReady == 1, "R1 reset inReady", int'(inReady), 1);

    for (int i = 0; i < 28; i++) begin sCnt[i] = pat[i]; sTag[i] = i + 1; end
    runStream(28, 0);
    for (int i = 0; i < 28; i++) begin sCnt[i] = pat[27-i]; sTag[i] = 33 + i; end
    runStream(28, 1);

    seqBusy(6, 0);
    seqBusy(7, 1);
    seqBusy(15, 2);

    // R8: flush in the middle of a long sequence
    @(negedge clk);
    inValid = 3'b001; inCount = {8'h0, 4'd15}; inTag = {12'h0, 6'd21}; outReady = 1;
    #1;
    chk(inTake == 2'd1, "R4 long accept before flush", int'(inTake), 1);
    @(negedge clk);
    inValid = '0; outReady = 0; flush = 1;
    #1;
    chk(inReady == 0, "R8 ready during flush", int'(inReady), 0);
    @(negedge clk);
    flush = 0;
    #1;
    chk(outValid == 0, "R8 queue empty after flush", int'(outValid), 0);
    chk(inReady == 1, "R8 ready after flush", int'(inReady), 1);
    expU.delete(); expB.delete();
    sCnt[0] = 3; sTag[0] = 9; sCnt[1] = 1; sTag[1] = 10;
    runStream(2, 0);
    chk(expU.size() == 0, "R8 no leftover", expU.size(), 0);

    report();
    $finish;
  end
endmodule